// File: doc/BRIEF.md
# Four-Channel Sample Address Sequencer

This block generates playback read addresses for four independent audio channels that share one external byte-wide sample memory. Each channel holds two register sets, called group A and group B, and each set holds a first and a last byte address. A play command for one channel and group copies that set into the channel's live pointer. The channel then emits 4-bit sample codes at its own programmed rate until it has used the last byte, and raises a one-cycle end pulse when it finishes.

Every byte carries two samples, and the low half is emitted first. Each channel keeps one byte ahead of its output in a private buffer. A round-robin arbiter grants at most one buffer refill per cycle on the shared memory bus. Decoding the sample codes, mixing and volume belong to downstream logic.

Top module: `snd_addr_seq`

## Requirements
- R1: After reset, `mem_ce_n` and `mem_oe_n` are high, and `nib_valid`, `active` and `snd_end` are all zero. Every channel's rate code is 0.
- R2: A command is taken on a clock edge where `cmd_valid` is high. The `cmd_op` field selects the action: 0 stores `cmd_addr` as the first address, 1 stores it as the last address, 2 starts playback, and 3 stores `cmd_rate` as the channel's rate code. `cmd_sel[2:1]` names the channel (0 to 3), and `cmd_sel[0]` names the group (0 = A, 1 = B). For the rate command, `cmd_sel[0]` is ignored.
- R3: While a channel is active, it makes a sample tick every 8 + (31 - rate) clock cycles. Rate code 31 gives 8 cycles and code 0 gives 39 cycles. The first tick comes that many cycles after the play edge.
- R4: On each tick, the channel pulses its `nib_valid` bit for one cycle and presents a 4-bit code on its `nib_data` slice (bits 4c+3 down to 4c). The first tick of a byte gives bits 3:0 of the byte and the second tick gives bits 7:4.
- R5: A channel reads bytes from its first address upward, one byte per two ticks, up to and including its last address. If the last address is below the first address, exactly one byte (two codes) is played.
- R6: In the cycle where the second code of the final byte is valid, `snd_end` for that channel pulses for one cycle and `active` for that channel falls.
- R7: Starting one group of a channel stops whatever that channel was playing, including the other group. Playback then restarts from the new group's first address with fresh tick timing.
- R8: A memory read lasts one cycle. During it, `mem_ce_n` and `mem_oe_n` are low together and `mem_addr` is the requesting channel's current byte address. `mem_data` is captured at the end of that cycle. At most one channel is served per cycle, in round-robin order.
- R9: All four channels can play at the same time at different rates without affecting each other's codes or timing.
- R10: Storing a new first or last address while a channel plays has no effect on the playback already running.
- R11: A rate command issued during playback changes the tick spacing from the next tick onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | Command action code |
| cmd_sel | input | 3 | Channel number and group |
| cmd_addr | input | 24 | Address operand for the load commands |
| cmd_rate | input | 5 | Rate code operand |
| mem_addr | output | 24 | Sample memory byte address |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_data | input | 8 | Byte read from sample memory |
| nib_valid | output | 4 | Per-channel sample code strobe |
| nib_data | output | 16 | Per-channel 4-bit sample codes |
| active | output | 4 | Per-channel playback in progress |
| snd_end | output | 4 | Per-channel end-of-sound pulse |

## Verification
A pointer that is off by one shows at the ports the first time its channel reads memory, as a `mem_addr` that matches no active channel's expected byte. It also shows within two ticks as wrong sample codes. A wrong tick counter or rate register moves a `nib_valid` pulse by one or more cycles, so the per-cycle comparison against the reference model catches it at the first tick. A wrong half-byte phase flag swaps the order of the codes, and a wrong last-byte test moves the `snd_end` pulse. Both show up within one byte of playback.

// File: rtl/snd_seq_pkg.sv
package snd_seq_pkg;

  typedef enum logic [1:0] {
    OP_LD_FIRST = 2'd0,
    OP_LD_LAST  = 2'd1,
    OP_PLAY     = 2'd2,
    OP_RATE     = 2'd3
  } seq_op_e;

  // Tick spacing in clocks: base plus the distance of the code from the top code.
  function automatic int unsigned period_of(input int unsigned base,
                                            input int unsigned rmax,
                                            input int unsigned rate);
    return base + rmax - rate;
  endfunction

  // Pick the half of a byte that goes out on a given phase (0 = low half first).
  function automatic logic [3:0] half_of(input logic [7:0] b, input logic ph);
    return ph ? b[7:4] : b[3:0];
  endfunction

endpackage

// File: rtl/snd_rr.sv
module snd_rr #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [IW-1:0] last_q;
  logic [IW-1:0] win_idx;

  always_comb begin
    grant   = '0;
    win_idx = last_q;
    for (int k = 1; k <= N; k++) begin
      int idx;
      idx = (int'(last_q) + k) % N;
      if (grant == '0 && req[idx]) begin
        grant[idx] = 1'b1;
        win_idx    = IW'(idx);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          last_q <= IW'(N - 1);
    else if (|grant)     last_q <= win_idx;
  end
endmodule

// File: rtl/snd_chan.sv
module snd_chan
  import snd_seq_pkg::*;
#(
  parameter int AW   = 24,
  parameter int DW   = 8,
  parameter int RW   = 5,
  parameter int BASE = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          play,
  input  logic          ld_first,
  input  logic          ld_last,
  input  logic          grp,
  input  logic [AW-1:0] ld_addr,
  input  logic          set_rate,
  input  logic [RW-1:0] rate_in,
  input  logic          grant,
  input  logic [DW-1:0] mem_data,
  output logic          req,
  output logic [AW-1:0] ptr,
  output logic          nib_valid,
  output logic [DW/2-1:0] nib,
  output logic          end_pulse,
  output logic          active
);
  localparam int RMAX = (1 << RW) - 1;
  localparam int CW   = $clog2(BASE + RMAX + 1);

  logic [AW-1:0] first_q [2];
  logic [AW-1:0] last_q  [2];
  logic [AW-1:0] ptr_q, lim_q;
  logic [RW-1:0] rate_q;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] buf_q;
  logic          full_q, phase_q, act_q;

  logic [CW-1:0] period;
  logic          tick, last_byte;

  assign period    = CW'(period_of(BASE, RMAX, int'(rate_q)));
  assign tick      = act_q && !play && (cnt_q >= period - CW'(1));
  assign last_byte = (ptr_q >= lim_q);
  assign req       = act_q && !full_q;
  assign ptr       = ptr_q;
  assign active    = act_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int g = 0; g < 2; g++) begin
        first_q[g] <= '0;
        last_q[g]  <= '0;
      end
      rate_q <= '0;
    end else begin
      if (ld_first) first_q[grp] <= ld_addr;
      if (ld_last)  last_q[grp]  <= ld_addr;
      if (set_rate) rate_q       <= rate_in;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q     <= 1'b0;
      ptr_q     <= '0;
      lim_q     <= '0;
      cnt_q     <= '0;
      buf_q     <= '0;
      full_q    <= 1'b0;
      phase_q   <= 1'b0;
      nib_valid <= 1'b0;
      nib       <= '0;
      end_pulse <= 1'b0;
    end else begin
      nib_valid <= 1'b0;
      end_pulse <= 1'b0;
      if (play) begin
        act_q   <= 1'b1;
        ptr_q   <= first_q[grp];
        lim_q   <= last_q[grp];
        cnt_q   <= '0;
        full_q  <= 1'b0;
        phase_q <= 1'b0;
      end else begin
        if (act_q) cnt_q <= tick ? '0 : cnt_q + CW'(1);
        if (grant) begin
          buf_q  <= mem_data;
          full_q <= 1'b1;
        end
        if (tick && full_q) begin
          nib_valid <= 1'b1;
          nib       <= half_of(buf_q, phase_q);
          phase_q   <= ~phase_q;
          if (phase_q) begin
            full_q <= 1'b0;
            if (last_byte) begin
              act_q     <= 1'b0;
              end_pulse <= 1'b1;
            end else begin
              ptr_q <= ptr_q + AW'(1);
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/snd_addr_seq.sv
module snd_addr_seq
  import snd_seq_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int AW   = 24,
  parameter int DW   = 8,
  parameter int RW   = 5,
  parameter int BASE = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_valid,
  input  logic [1:0]            cmd_op,
  input  logic [$clog2(NCH):0]  cmd_sel,
  input  logic [AW-1:0]         cmd_addr,
  input  logic [RW-1:0]         cmd_rate,
  output logic [AW-1:0]         mem_addr,
  output logic                  mem_ce_n,
  output logic                  mem_oe_n,
  input  logic [DW-1:0]         mem_data,
  output logic [NCH-1:0]        nib_valid,
  output logic [NCH*DW/2-1:0]   nib_data,
  output logic [NCH-1:0]        active,
  output logic [NCH-1:0]        snd_end
);
  localparam int CHW = $clog2(NCH);
  localparam int NW  = DW / 2;

  logic [NCH-1:0] req, grant;
  logic [AW-1:0]  ptr_all [NCH];
  logic [CHW-1:0] sel_ch;
  logic           sel_grp;
  seq_op_e        op;

  assign sel_ch  = cmd_sel[CHW:1];
  assign sel_grp = cmd_sel[0];
  assign op      = seq_op_e'(cmd_op);

  snd_rr #(.N(NCH)) u_rr (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (req),
    .grant (grant)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic hit;
    assign hit = cmd_valid && (sel_ch == CHW'(c));

    snd_chan #(.AW(AW), .DW(DW), .RW(RW), .BASE(BASE)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .play      (hit && op == OP_PLAY),
      .ld_first  (hit && op == OP_LD_FIRST),
      .ld_last   (hit && op == OP_LD_LAST),
      .grp       (sel_grp),
      .ld_addr   (cmd_addr),
      .set_rate  (hit && op == OP_RATE),
      .rate_in   (cmd_rate),
      .grant     (grant[c]),
      .mem_data  (mem_data),
      .req       (req[c]),
      .ptr       (ptr_all[c]),
      .nib_valid (nib_valid[c]),
      .nib       (nib_data[c*NW +: NW]),
      .end_pulse (snd_end[c]),
      .active    (active[c])
    );
  end

  always_comb begin
    mem_addr = '0;
    for (int c = 0; c < NCH; c++)
      if (grant[c]) mem_addr = mem_addr | ptr_all[c];
  end

  assign mem_ce_n = ~|grant;
  assign mem_oe_n = ~|grant;
endmodule

// File: rtl/snd_addr_seq_chk.sv
module snd_addr_seq_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           mem_ce_n,
  input logic           mem_oe_n,
  input logic [NCH-1:0] req,
  input logic [NCH-1:0] grant,
  input logic [NCH-1:0] nib_valid,
  input logic [NCH-1:0] active,
  input logic [NCH-1:0] snd_end
);
  assert_strobes_paired_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ce_n == mem_oe_n);

  assert_single_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  assert_grant_needs_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~req) == '0);

  assert_bus_serves_waiter_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|req) |-> !mem_ce_n);

  assert_code_from_active_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (nib_valid & ~$past(active)) == '0);

  assert_end_drops_active_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (snd_end & active) == '0);

  assert_end_with_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (snd_end & ~nib_valid) == '0);
endmodule

bind snd_addr_seq snd_addr_seq_chk #(.NCH(NCH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mem_ce_n  (mem_ce_n),
  .mem_oe_n  (mem_oe_n),
  .req       (req),
  .grant     (grant),
  .nib_valid (nib_valid),
  .active    (active),
  .snd_end   (snd_end)
);

// File: tb/sim_snd_addr_seq.sv
`timescale 1ns/1ps
module sim_snd_addr_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = '0;
  logic [2:0]  cmd_sel = '0;
  logic [23:0] cmd_addr = '0;
  logic [4:0]  cmd_rate = '0;
  logic [23:0] mem_addr;
  logic        mem_ce_n, mem_oe_n;
  logic [7:0]  mem_data;
  logic [3:0]  nib_valid, active, snd_end;
  logic [15:0] nib_data;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit model_on = 1'b0;

  always #4 clk = ~clk;

  function automatic logic [7:0] romf(input logic [23:0] a);
    logic [7:0] v;
    v = a[7:0] * 8'd29 + a[15:8] * 8'd3 + a[23:16];
    return v;
  endfunction

  assign mem_data = mem_oe_n ? 8'h00 : romf(mem_addr);

  snd_addr_seq u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_sel(cmd_sel), .cmd_addr(cmd_addr), .cmd_rate(cmd_rate),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_data(mem_data), .nib_valid(nib_valid), .nib_data(nib_data),
    .active(active), .snd_end(snd_end)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // Behavioural reference model, stepped on every rising edge.
  int m_first[4][2], m_last[4][2], m_rate[4];
  int m_act[4], m_ptr[4], m_lim[4], m_ph[4], m_cnt[4];
  int e_v[4], e_n[4], e_end[4];

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      for (int c = 0; c < 4; c++) begin
        m_rate[c] = 0; m_act[c] = 0; m_ptr[c] = 0; m_lim[c] = 0;
        m_ph[c] = 0; m_cnt[c] = 0; e_v[c] = 0; e_n[c] = 0; e_end[c] = 0;
        m_first[c][0] = 0; m_first[c][1] = 0; m_last[c][0] = 0; m_last[c][1] = 0;
      end
    end else begin
      for (int c = 0; c < 4; c++) begin
        bit hit;
        int per;
        hit = cmd_valid && (int'(cmd_sel[2:1]) == c);
        e_v[c] = 0; e_end[c] = 0;
        per = 8 + 31 - m_rate[c];
        if (hit && cmd_op == 2'd2) begin
          m_act[c] = 1; m_ptr[c] = m_first[c][cmd_sel[0]];
          m_lim[c] = m_last[c][cmd_sel[0]]; m_cnt[c] = 0; m_ph[c] = 0;
        end else if (m_act[c] != 0) begin
          if (m_cnt[c] >= per - 1) begin
            logic [7:0] b;
            m_cnt[c] = 0;
            b = romf(24'(m_ptr[c]));
            e_v[c] = 1;
            e_n[c] = (m_ph[c] != 0) ? int'(b >> 4) : int'(b & 8'h0f);
            if (m_ph[c] != 0) begin
              if (m_ptr[c] >= m_lim[c]) begin m_act[c] = 0; e_end[c] = 1; end
              else m_ptr[c] = m_ptr[c] + 1;
            end
            m_ph[c] = 1 - m_ph[c];
          end else m_cnt[c] = m_cnt[c] + 1;
        end
        if (hit && cmd_op == 2'd0) m_first[c][cmd_sel[0]] = int'(cmd_addr);
        if (hit && cmd_op == 2'd1) m_last[c][cmd_sel[0]]  = int'(cmd_addr);
        if (hit && cmd_op == 2'd3) m_rate[c] = int'(cmd_rate);
      end
    end
  end

  // Per-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    if (model_on && rst_n) begin
      for (int c = 0; c < 4; c++) begin
        chk(nib_valid[c] == e_v[c][0], $sformatf("R3 R9 R11 strobe ch%0d", c), nib_valid[c], e_v[c]);
        if (e_v[c] != 0)
          chk(int'(nib_data[c*4 +: 4]) == e_n[c], $sformatf("R4 R5 R7 R10 code ch%0d", c),
              nib_data[c*4 +: 4], e_n[c]);
        chk(snd_end[c] == e_end[c][0], $sformatf("R6 end ch%0d", c), snd_end[c], e_end[c]);
        chk(active[c] == m_act[c][0], $sformatf("R2 R6 R7 active ch%0d", c), active[c], m_act[c]);
      end
      if (!mem_ce_n) begin
        bit found = 1'b0;
        for (int c = 0; c < 4; c++)
          if (m_act[c] != 0 && m_ptr[c] == int'(mem_addr)) found = 1'b1;
        chk(found && !mem_oe_n, "R8 read address/strobes", mem_addr, 0);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog expired", cyc, 0);
    finish_up();
  end

  task automatic cmd(input int op, input int ch, input int grp, input int addr, input int rate);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'(op); cmd_sel = {2'(ch), 1'(grp)};
    cmd_addr = 24'(addr); cmd_rate = 5'(rate);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic setup(input int ch, input int grp, input int a0, input int a1);
    cmd(0, ch, grp, a0, 0);
    cmd(1, ch, grp, a1, 0);
  endtask

  initial begin
    int k, codes, ends;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle after reset
    chk(mem_ce_n && mem_oe_n, "R1 strobes high", {mem_ce_n, mem_oe_n}, 3);
    chk(nib_valid == 0 && active == 0 && snd_end == 0, "R1 outputs idle",
        {nib_valid, active, snd_end}, 0);
    model_on = 1'b1;

    // R3 R4 R5 R6: single channel at the fastest rate
    setup(0, 0, 24'h000100, 24'h000102);
    cmd(3, 0, 0, 0, 31);
    cmd(2, 0, 0, 0, 0);
    k = 0;
    while (!nib_valid[0] && k < 100) begin @(negedge clk); k++; end
    chk(k == 8, "R3 first tick after play", k, 8);
    chk(nib_data[3:0] == romf(24'h000100) & 8'h0f, "R4 low half first",
        nib_data[3:0], romf(24'h000100) & 8'h0f);
    codes = 1; ends = 0;
    while (active[0] && k < 200) begin
      @(negedge clk); k++;
      if (nib_valid[0]) codes++;
      if (snd_end[0]) ends++;
    end
    chk(codes == 6, "R5 codes for three bytes", codes, 6);
    chk(ends == 1, "R6 one end pulse", ends, 1);

    // R9: all four channels together, R5 reversed range on ch0
    setup(1, 1, 24'h123456, 24'h123457); cmd(3, 1, 0, 0, 20);
    setup(2, 0, 24'hFFFFF0, 24'hFFFFF1); cmd(3, 2, 0, 0, 31);
    setup(3, 0, 24'h400000, 24'h400003); cmd(3, 3, 0, 0, 0);
    setup(0, 1, 24'h000200, 24'h0001FF); cmd(3, 0, 0, 0, 10);
    cmd(2, 0, 1, 0, 0);
    cmd(2, 1, 1, 0, 0);
    cmd(2, 2, 0, 0, 0);
    cmd(2, 3, 0, 0, 0);
    codes = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (nib_valid[0]) codes++;
    end
    chk(codes == 2, "R5 reversed range plays one byte", codes, 2);
    chk(active == 0, "R9 all channels finished", active, 0);

    // R7 R10: reload during play, then switch group
    setup(1, 0, 24'h000050, 24'h000060);
    cmd(2, 1, 0, 0, 0);
    repeat (30) @(negedge clk);
    cmd(1, 1, 0, 24'h000051, 0);
    repeat (60) @(negedge clk);
    chk(active[1] == 1'b1, "R10 reload ignored by running play", active[1], 1);
    cmd(2, 1, 1, 0, 0);
    repeat (150) @(negedge clk);
    chk(active[1] == 1'b0, "R7 other group replaced and finished", active[1], 0);

    // R11: rate change mid-play
    cmd(3, 2, 0, 0, 0);
    cmd(2, 2, 0, 0, 0);
    repeat (50) @(negedge clk);
    cmd(3, 2, 0, 0, 31);
    repeat (200) @(negedge clk);
    chk(active[2] == 1'b0, "R11 faster rate finished playback", active[2], 0);

    repeat (20) @(negedge clk);
    finish_up();
  end
endmodule